// File: doc/BRIEF.md
# Berger Code Generator and Checker with Two-Rail Verdict

This block serves a datapath that protects a K-bit information word with a Berger code. It has two jobs. The first is to produce the check field for an outgoing word, which is the binary count of the zero bits in that word. The second is to judge a received word together with its received check field.

The verdict is not a single flag. It is carried on a pair of complementary rails. Unequal rails mean the codeword is good, and equal rails mean an error. With this encoding, a stuck wire on the indicator shows up as an error instead of staying hidden.

The checker recomputes the zero count and forms one rail pair for each check bit. The first rail of a pair is the recomputed bit. The second rail is the inverse of the received bit. The pairs are then merged by a balanced tree of two-rail merge cells into a single pair. A registered copy of the final pair is provided for timing closure.

Because of how the check field is defined, every unidirectional error on a valid codeword produces a mismatch. This holds for any number of bits in the information field, the check field, or both.

Top module: `berger_tworail_checker`

## Requirements
- R1: `gen_chk_o` equals the number of zero bits in `info_i`, as an unsigned binary value.
- R2: The check field width is ceil(log2(K+1)): 4 bits for K=8, giving a 12-bit codeword, and 3 bits for K=7. With K=7, an information word of 7'b1000101 yields a check field of 3'b100.
- R3: When `chk_i` equals the zero count of `info_i`, the two bits of `rail_o` differ (2'b01 or 2'b10).
- R4: When `chk_i` differs from the zero count of `info_i` in any bit, the two bits of `rail_o` are equal (2'b00 or 2'b11).
- R5: For a valid codeword, any non-empty set of bit flips in one direction only (all 1→0, or all 0→1) drives `rail_o` to equal bits. The flips may fall anywhere across the information and check fields.
- R6: `rail_q_o` holds the value `rail_o` had at the previous rising clock edge.
- R7: While `rst_n` is low, `rail_q_o` is 2'b01 (bit 0 high, bit 1 low), which is a no-error code.
- R8: The merge cell maps input pairs (a0,a1) and (b0,b1) to c0 = a0·b0 + a1·b1 and c1 = a0·b1 + a1·b0. Its output bits differ exactly when both input pairs have differing bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the registered verdict |
| rst_n | input | 1 | Asynchronous active-low reset |
| info_i | input | K | Information word (generated and checked) |
| chk_i | input | CW | Received check field |
| gen_chk_o | output | CW | Generated check field (zero count of `info_i`) |
| rail_o | output | 2 | Combinational two-rail verdict, unequal means good |
| rail_q_o | output | 2 | Registered copy of `rail_o` |

## Verification
Check-field generation and codeword judgement act on the same `info_i` in the same cycle. The bench therefore drives each word together with a received check field that is either the correct count or a unidirectionally corrupted one. It then judges `gen_chk_o` and `rail_o` from the same sample, against a zero count it computes by its own loop.

The combinational and registered verdicts also overlap: `rail_o` moves with new inputs while `rail_q_o` updates at the edge. After each edge the bench compares `rail_q_o` with the combinational verdict it sampled just before that edge.

// File: rtl/berger_pkg.sv
package berger_pkg;

  // Widest information word the helper functions accept.
  localparam int MAXW = 64;

  // Width of a binary count that can reach k.
  function automatic int check_width(input int k);
    return $clog2(k + 1);
  endfunction

  // Count of zero bits among the low k bits of w.
  function automatic int zero_count(input logic [MAXW-1:0] w, input int k);
    int n;
    n = 0;
    for (int i = 0; i < MAXW; i++) begin
      if (i < k && !w[i]) n++;
    end
    return n;
  endfunction

endpackage

// File: rtl/berger_check_gen.sv
module berger_check_gen #(
  parameter int K  = 8,
  parameter int CW = berger_pkg::check_width(K)
) (
  input  logic [K-1:0]  info,
  output logic [CW-1:0] chk
);
  always_comb begin
    chk = CW'(berger_pkg::zero_count(berger_pkg::MAXW'(info), K));
  end
endmodule

// File: rtl/tworail_cell.sv
module tworail_cell (
  input  logic a0,
  input  logic a1,
  input  logic b0,
  input  logic b1,
  output logic c0,
  output logic c1
);
  // A valid pair has unequal bits; output valid only if both inputs valid.
  assign c0 = (a0 & b0) | (a1 & b1);
  assign c1 = (a0 & b1) | (a1 & b0);
endmodule

// File: rtl/tworail_tree.sv
module tworail_tree #(
  parameter int N = 4
) (
  input  logic [N-1:0] p0,
  input  logic [N-1:0] p1,
  output logic         r0,
  output logic         r1
);
  localparam int LEAVES = 1 << $clog2(N);
  localparam int NODES  = 2 * LEAVES - 1;

  // Heap layout: node i has children 2i and 2i+1; leaves at LEAVES..NODES.
  logic [NODES:1] n0;
  logic [NODES:1] n1;

  for (genvar j = 0; j < LEAVES; j++) begin : g_leaf
    if (j < N) begin : g_real
      assign n0[LEAVES+j] = p0[j];
      assign n1[LEAVES+j] = p1[j];
    end else begin : g_pad
      // Padding with a valid pair only swaps rails, never hides an error.
      assign n0[LEAVES+j] = 1'b0;
      assign n1[LEAVES+j] = 1'b1;
    end
  end

  for (genvar i = 1; i < LEAVES; i++) begin : g_node
    tworail_cell u_cell (
      .a0(n0[2*i]),   .a1(n1[2*i]),
      .b0(n0[2*i+1]), .b1(n1[2*i+1]),
      .c0(n0[i]),     .c1(n1[i])
    );
  end

  assign r0 = n0[1];
  assign r1 = n1[1];
endmodule

// File: rtl/berger_tworail_checker.sv
module berger_tworail_checker #(
  parameter int K = 8,
  localparam int CW = berger_pkg::check_width(K)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [K-1:0]  info_i,
  input  logic [CW-1:0] chk_i,
  output logic [CW-1:0] gen_chk_o,
  output logic [1:0]    rail_o,
  output logic [1:0]    rail_q_o
);
  localparam logic [1:0] RAIL_RESET = 2'b01;

  logic [CW-1:0] recount;
  logic [CW-1:0] pair_hi;
  logic [CW-1:0] pair_lo;
  logic          root0;
  logic          root1;

  berger_check_gen #(.K(K), .CW(CW)) u_gen (
    .info(info_i),
    .chk (recount)
  );

  // Per check bit: recomputed bit against inverted received bit.
  assign pair_hi = recount;
  assign pair_lo = ~chk_i;

  tworail_tree #(.N(CW)) u_tree (
    .p0(pair_hi),
    .p1(pair_lo),
    .r0(root0),
    .r1(root1)
  );

  assign gen_chk_o = recount;
  assign rail_o    = {root1, root0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rail_q_o <= RAIL_RESET;
    else        rail_q_o <= rail_o;
  end
endmodule

// File: rtl/berger_tworail_sva.sv
module berger_tworail_sva #(
  parameter int K  = 8,
  parameter int CW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic [K-1:0]  info_i,
  input logic [CW-1:0] chk_i,
  input logic [CW-1:0] gen_chk_o,
  input logic [1:0]    rail_o,
  input logic [1:0]    rail_q_o
);
  // R1
  gen_is_zero_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gen_chk_o == CW'(K - $countones(info_i)));

  // R3
  match_gives_split_rails_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_i == CW'(K - $countones(info_i))) |-> (rail_o[0] != rail_o[1]));

  // R4
  mismatch_gives_equal_rails_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_i != CW'(K - $countones(info_i))) |-> (rail_o[0] == rail_o[1]));

  // R6
  registered_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (rail_q_o == $past(rail_o)));

  // R7
  reset_code_chk: assert property (@(posedge clk)
    !rst_n |=> (rail_q_o == 2'b01));
endmodule

bind berger_tworail_checker berger_tworail_sva #(.K(K), .CW(CW)) u_sva (
  .clk(clk), .rst_n(rst_n), .info_i(info_i), .chk_i(chk_i),
  .gen_chk_o(gen_chk_o), .rail_o(rail_o), .rail_q_o(rail_q_o)
);

// File: tb/tb_berger_tworail_checker.sv
module tb_berger_tworail_checker;
  localparam int K  = 8;
  localparam int CW = 4;

  logic clk = 0;
  logic rst_n = 0;
  always #5 clk = ~clk;

  logic [K-1:0]  info;
  logic [CW-1:0] chk;
  logic [CW-1:0] gen;
  logic [1:0]    rail, rail_q;

  berger_tworail_checker #(.K(K)) dut (
    .clk(clk), .rst_n(rst_n), .info_i(info), .chk_i(chk),
    .gen_chk_o(gen), .rail_o(rail), .rail_q_o(rail_q)
  );

  logic [6:0] info7;
  logic [2:0] chk7, gen7;
  logic [1:0] rail7, rail7_q;

  berger_tworail_checker #(.K(7)) dut7 (
    .clk(clk), .rst_n(rst_n), .info_i(info7), .chk_i(chk7),
    .gen_chk_o(gen7), .rail_o(rail7), .rail_q_o(rail7_q)
  );

  logic ca0, ca1, cb0, cb1, cc0, cc1;
  tworail_cell u_cell (.a0(ca0), .a1(ca1), .b0(cb0), .b1(cb1), .c0(cc0), .c1(cc1));

  int nvec = 0;
  int nbad = 0;
  bit done = 0;

  // {info, received check, expect error}
  localparam logic [12:0] VEC [10] = '{
    {8'hFF, 4'd0, 1'b0}, {8'h00, 4'd8, 1'b0}, {8'hA5, 4'd4, 1'b0},
    {8'h80, 4'd7, 1'b0}, {8'h7F, 4'd1, 1'b0}, {8'h3C, 4'd4, 1'b0},
    {8'hFF, 4'd1, 1'b1}, {8'h00, 4'd0, 1'b1}, {8'hA5, 4'd5, 1'b1},
    {8'h0F, 4'd15, 1'b1}
  };

  function automatic int zeros8(input logic [7:0] w);
    int n = 8;
    for (int b = 0; b < 8; b++) n -= int'(w[b]);
    return n;
  endfunction

  task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive one word; judge generation and verdict, then the registered copy.
  task automatic apply(input logic [7:0] i, input logic [3:0] c, input bit exp_err);
    logic [1:0] seen;
    @(negedge clk);
    info = i; chk = c;
    #1;
    check(gen == 4'(zeros8(i)), "R1", 16'(gen), 16'(zeros8(i)));
    if (exp_err) check(rail[0] == rail[1], "R4/R5", 16'(rail), 16'h0);
    else         check(rail[0] != rail[1], "R3", 16'(rail), 16'h1);
    seen = rail;
    @(posedge clk); #1;
    check(rail_q == seen, "R6", 16'(rail_q), 16'(seen));
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      nvec++; nbad++;
      $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    info = 8'hFF; chk = 4'd0; info7 = 7'd0; chk7 = 3'd0;
    ca0 = 0; ca1 = 0; cb0 = 0; cb1 = 0;
    repeat (3) @(posedge clk);
    #1;
    // R7: reset code held while reset is low
    check(rail_q == 2'b01, "R7", 16'(rail_q), 16'h1);
    @(negedge clk); rst_n = 1;

    foreach (VEC[v]) apply(VEC[v][12:5], VEC[v][4:1], VEC[v][0]);

    // R5: exhaustive words, clean codeword plus unidirectional corruptions
    for (int w = 0; w < 256; w++) begin
      logic [7:0] iw;
      logic [3:0] cw;
      iw = 8'(w);
      cw = 4'(zeros8(iw));
      apply(iw, cw, 1'b0);
      for (int t = 0; t < 4; t++) begin
        logic [7:0] mi;
        logic [3:0] mc;
        mi = 8'(w * 7 + t * 53 + 1);
        mc = 4'(t * 5 + w);
        if (((iw & ~mi) != iw) || ((cw & ~mc) != cw))
          apply(iw & ~mi, cw & ~mc, 1'b1);
        if (((iw | mi) != iw) || ((cw | mc) != cw))
          apply(iw | mi, cw | mc, 1'b1);
      end
    end

    // R2: 7-bit word 1000101 gives 3-bit field 100; width 4 at K=8
    @(negedge clk); info7 = 7'b1000101; chk7 = 3'b100; #1;
    check(gen7 == 3'b100, "R2", 16'(gen7), 16'h4);
    check(rail7[0] != rail7[1], "R2", 16'(rail7), 16'h1);
    check($bits(gen) == 4, "R2", 16'($bits(gen)), 16'h4);

    // R8: merge cell, all sixteen input combinations
    for (int m = 0; m < 16; m++) begin
      logic [3:0] mm;
      mm = 4'(m);
      ca0 = mm[0]; ca1 = mm[1]; cb0 = mm[2]; cb1 = mm[3];
      #1;
      check(cc0 == ((mm[0] & mm[2]) | (mm[1] & mm[3])), "R8", 16'(cc0), 16'h0);
      check(cc1 == ((mm[0] & mm[3]) | (mm[1] & mm[2])), "R8", 16'(cc1), 16'h0);
      check((cc0 != cc1) == ((mm[0] != mm[1]) && (mm[2] != mm[3])), "R8",
            16'({cc1, cc0}), 16'(mm));
    end

    // R7: reset reasserted mid-run returns the no-error code
    @(negedge clk); rst_n = 0; #1;
    check(rail_q == 2'b01, "R7", 16'(rail_q), 16'h1);
    @(posedge clk); #1;
    check(rail_q == 2'b01, "R7", 16'(rail_q), 16'h1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule